// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link. One 8-bit register holds the outgoing byte. As each bit leaves on the data output, the bit from the data input shifts in behind it. At the end of a transfer the same register holds the received byte. There is no separate buffer. Writing the data register starts a transfer at once. A one-cycle interrupt pulse marks the sampling edge of the eighth clock pulse.

The transfer clock is either generated inside the block or taken from the clock pin. An internal clock is derived from one of three prescaled enable inputs and an 8-bit divider. It produces exactly eight pulses and then rests at its idle level. An external clock is followed edge by edge after a two-stage synchronizer. Software can choose the bit order, which clock edge launches data and which edge samples it, and the level the data pin shows while idle in external mode. With the internal clock, the data pin is floated when idle. It keeps the last bit for half a transfer clock after the final pulse, unless a new write cuts that hold short.

Top module: `sync_shift_port`

## Requirements
- R1: After reset `busy`, `irq` and `sd_oe` are 0, `sclk_oe` is 1, and `sclk_o` is 1. The control register resets to internal clock, `pre_en[0]`, LSB first, polarity 0.
- R2: A `wr_data` write loads `wdata` into the shift register and sets `busy` from the next cycle. `busy` clears on the same edge as the eighth sampling edge.
- R3: Control field `wdata[1:0]` selects the clock enable: 0 for `pre_en[0]`, 1 for `pre_en[1]`, 2 or 3 for `pre_en[2]`. With internal clock (`wdata[2]`=0), each half period of `sclk_o` lasts n+1 enable ticks, where n is the divider value written with `wr_div`.
- R4: With internal clock, exactly eight pulses appear on `sclk_o` per write. Afterwards it rests at the inverse of the polarity bit (`wdata[4]`): high for 0, low for 1.
- R5: With polarity 0, the data output changes on the falling clock edge and the input is sampled on the rising edge. With polarity 1 these edges are swapped.
- R6: Control bit `wdata[3]`=1 sends bit 7 first; 0 sends bit 0 first.
- R7: The bits sampled from `sd_i` are assembled in the shift register in the selected order. After the interrupt, `rx_data` holds the received byte.
- R8: `irq` is a single-cycle pulse issued together with the eighth sampling edge, once per transfer.
- R9: With internal clock, `sd_oe` is 0 from the write until the first launching edge. After the last pulse it stays 1 for exactly one half period, then drops to 0.
- R10: A `wr_data` write during that half-period hold drives `sd_oe` to 0 on the next cycle.
- R11: With external clock (`wdata[2]`=1), `sclk_oe` is 0 and `sd_oe` is 1. Shifting follows synchronized `sclk_i` edges. While not busy, `sd_o` shows the idle-level bit `wdata[5]`.
- R12: With external clock, edges after the eighth keep shifting the register but raise no further interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_en | input | 3 | Prescaled clock enables (fine, medium, coarse) |
| wr_ctrl | input | 1 | Write `wdata[5:0]` to the control register |
| wr_div | input | 1 | Write `wdata` to the divider register |
| wr_data | input | 1 | Write `wdata` to the shift register and start a transfer |
| wdata | input | 8 | Write data |
| rx_data | output | 8 | Shift register contents |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion pulse |
| sclk_i | input | 1 | External transfer clock |
| sclk_o | output | 1 | Internal transfer clock |
| sclk_oe | output | 1 | Clock pin drive enable |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| sd_oe | output | 1 | Data pin drive enable |

## Verification
On every cycle, the assertions check these relations: the interrupt is a single-cycle pulse that coincides with the fall of `busy`; the bit counter is at rest whenever no transfer runs; an idle internal clock sits at its polarity's rest level; an idle internal port never drives the data pin; and a data write always floats the pin on the next cycle. The remaining behaviour is shown only by the bench scenarios, which act as the link partner. These include the exact pulse period for each enable and divider, the bit order, the edges on which data launches and is sampled, the received byte, the length of the hold, the cut-short hold, and the extra external edges that shift without an interrupt.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int W = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   pre_en,
  input  logic         wr_ctrl,
  input  logic         wr_div,
  input  logic         wr_data,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rx_data,
  output logic         busy,
  output logic         irq,
  input  logic         sclk_i,
  output logic         sclk_o,
  output logic         sclk_oe,
  input  logic         sd_i,
  output logic         sd_o,
  output logic         sd_oe
);
  logic [5:0]    ctrl;
  logic [W-1:0]  div, cnt, sr;
  logic [CW-1:0] nbit;
  logic [2:0]    sy;
  logic busy_r, hold, sclk_r, ph, out_bit, oe_r, irq_r, tick;

  wire ext = ctrl[2];
  wire msb = ctrl[3];
  wire pol = ctrl[4];
  wire idl = ctrl[5];

  always_comb
    case (ctrl[1:0])
      2'd0:    tick = pre_en[0];
      2'd1:    tick = pre_en[1];
      default: tick = pre_en[2];
    endcase

  wire run    = !ext && (busy_r || hold);
  wire half   = run && tick && (cnt == div);
  wire s_rise = sy[1] && !sy[2];
  wire s_fall = !sy[1] && sy[2];
  wire lead   = (half && busy_r && !ph) || (ext && (pol ? s_rise : s_fall));
  wire trail  = (half && busy_r && ph) || (ext && (pol ? s_fall : s_rise));
  wire done   = trail && busy_r && (nbit == CW'(W - 1));
  wire [W-1:0] shifted = msb ? {sr[W-2:0], sd_i} : {sd_i, sr[W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; div <= '0; cnt <= '0; sr <= '0; nbit <= '0; sy <= '1;
      busy_r <= 1'b0; hold <= 1'b0; sclk_r <= 1'b1; ph <= 1'b0;
      out_bit <= 1'b0; oe_r <= 1'b0; irq_r <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      sy <= {sy[1:0], sclk_i};
      if (wr_ctrl) begin
        ctrl <= wdata[5:0];
        if (!busy_r) sclk_r <= ~wdata[4];
      end
      if (wr_div) div <= wdata;
      if (run && tick) cnt <= (cnt == div) ? '0 : cnt + 1'b1;
      if (half && busy_r) begin
        sclk_r <= ~sclk_r;
        ph     <= ~ph;
      end
      if (lead) begin
        out_bit <= msb ? sr[W-1] : sr[0];
        if (!ext) oe_r <= 1'b1;
      end
      if (trail) begin
        sr <= shifted;
        if (busy_r) nbit <= nbit + 1'b1;
      end
      if (done) begin
        busy_r <= 1'b0;
        irq_r  <= 1'b1;
        hold   <= !ext;
        nbit   <= '0;
      end
      if (half && hold && !busy_r) begin
        hold <= 1'b0;
        oe_r <= 1'b0;
      end
      if (wr_data) begin
        sr <= wdata; busy_r <= 1'b1; hold <= 1'b0; oe_r <= 1'b0;
        cnt <= '0; ph <= 1'b0; nbit <= '0; out_bit <= idl;
        if (!ext) sclk_r <= ~pol;
      end
    end
  end

  assign rx_data = sr;
  assign busy    = busy_r;
  assign irq     = irq_r;
  assign sclk_o  = sclk_r;
  assign sclk_oe = !ext;
  assign sd_o    = (ext && !busy_r) ? idl : out_bit;
  assign sd_oe   = ext || oe_r;

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R8
  AST_IRQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (!busy && $past(busy))); // R2
  AST_COUNT_AT_REST: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (nbit == '0)); // R2
  AST_CLK_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !ext) |-> (sclk_o == !pol)); // R4
  AST_FLOAT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!ext && !busy && !hold) |-> !sd_oe); // R9
  AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n) (wr_data && !ext && !wr_ctrl) |=> !sd_oe); // R10
endmodule

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_ctrl = 0, wr_div = 0, wr_data = 0, sclk_i = 1, sd_i = 0;
  logic [7:0] wdata = 0;
  logic [2:0] pre_en;
  logic [7:0] rx_data;
  logic busy, irq, sclk_o, sclk_oe, sd_o, sd_oe;
  int nchk = 0, nerr = 0, irq_cnt = 0, gc = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) begin gc++; if (irq) irq_cnt++; end
  assign pre_en = {gc[4:0] == 5'd0, gc[2:0] == 3'd0, 1'b1};

  sync_shift_port u0 (.clk, .rst_n, .pre_en, .wr_ctrl, .wr_div, .wr_data, .wdata,
    .rx_data, .busy, .irq, .sclk_i, .sclk_o, .sclk_oe, .sd_i, .sd_o, .sd_oe);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  function automatic bit bsel(input [7:0] d, input int k, input bit m);
    return m ? d[7-k] : d[k];
  endfunction
  function automatic [7:0] rx_exp(input [7:0] s, input bit m);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) if (m) r[7-k] = s[k]; else r[k] = s[k];
    return r;
  endfunction
  function automatic int ratio(input [1:0] s);
    return s == 0 ? 1 : (s == 1 ? 8 : 32);
  endfunction

  task automatic wr(input int which, input [7:0] v);
    wdata = v; wr_ctrl = (which == 0); wr_div = (which == 1); wr_data = (which == 2);
    @(negedge clk);
    wr_ctrl = 0; wr_div = 0; wr_data = 0;
  endtask

  task automatic run_int(input [1:0] sel, input [7:0] n, input bit m, input bit p,
                         input [7:0] tx, input [7:0] rs, input bit cut);
    int H = (n + 1) * ratio(sel);
    int k = 0, guard = 0, last = -1, badper = 0, badtx = 0, badoe = 0, i0, h, moves;
    bit prev;
    wr(0, {3'b0, p, m, 1'b0, sel}); wr(1, n);
    chk(sclk_o == !p && sclk_oe, "R4 idle level", sclk_o, !p);
    i0 = irq_cnt;
    wr(2, tx);
    chk(busy && !sd_oe, "R2/R9 start", {busy, sd_oe}, 2'b10);
    prev = sclk_o;
    while (k < 8 && guard < 20000) begin
      @(negedge clk); guard++;
      if (sclk_o !== prev) begin
        if (sclk_o == p) begin
          if (last >= 0 && gc - last != 2 * H) badper++;
          last = gc; sd_i = rs[k];
          if (!sd_oe) badoe++;
        end else begin
          if (sd_o !== bsel(tx, k, m)) badtx++;
          if (k == 7) chk(irq && !busy, "R8 irq at last edge", {irq, busy}, 2'b10);
          k++;
        end
        prev = sclk_o;
      end
    end
    chk(k == 8, "R4 pulse count", k, 8);
    chk(badper == 0, "R3 period", badper, 0);
    chk(badtx == 0 && badoe == 0, "R5/R6 tx bits", badtx, 0);
    chk(rx_data == rx_exp(rs, m), "R7 rx byte", rx_data, rx_exp(rs, m));
    if (cut) begin
      wr(2, ~tx);
      chk(!sd_oe, "R10 hold cut", sd_oe, 0);
      guard = 0;
      while ((busy || sd_oe) && guard < 20000) begin @(negedge clk); guard++; end
      repeat (2 * H + 4) @(negedge clk);
    end else begin
      h = 0;
      while (sd_oe && h < 10000) begin @(negedge clk); h++; end
      chk(h == H, "R9 hold length", h, H);
      moves = 0;
      for (int c = 0; c < 2 * H + 4; c++) begin @(negedge clk); if (sclk_o != !p) moves++; end
      chk(moves == 0, "R4 clock stopped", moves, 0);
      chk(irq_cnt == i0 + 1, "R8 single irq", irq_cnt - i0, 1);
    end
  endtask

  task automatic ext_pulse(input bit p, input bit din, output bit dout);
    sclk_i = p; sd_i = din;
    repeat (4) @(negedge clk);
    dout = sd_o;
    sclk_i = !p;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_ext(input bit m, input bit p, input bit idl, input [7:0] tx, input [7:0] rs);
    int i0, badtx = 0;
    bit d;
    logic [7:0] e;
    sclk_i = !p; repeat (4) @(negedge clk);
    wr(0, {2'b0, idl, p, m, 1'b1, 2'b00});
    repeat (2) @(negedge clk);
    chk(sd_oe && !sclk_oe && sd_o == idl, "R11 ext idle", {sd_oe, sclk_oe, sd_o}, {2'b10, idl});
    i0 = irq_cnt;
    wr(2, tx);
    for (int k = 0; k < 8; k++) begin
      ext_pulse(p, rs[k], d);
      if (d !== bsel(tx, k, m)) badtx++;
    end
    chk(badtx == 0, "R11 ext tx bits", badtx, 0);
    chk(irq_cnt == i0 + 1 && !busy, "R8 ext irq", irq_cnt - i0, 1);
    e = rx_exp(rs, m);
    chk(rx_data == e, "R7 ext rx", rx_data, e);
    chk(sd_o == idl, "R11 idle after", sd_o, idl);
    ext_pulse(p, 1'b1, d);
    e = m ? {e[6:0], 1'b1} : {1'b1, e[7:1]};
    chk(rx_data == e && irq_cnt == i0 + 1, "R12 extra edge", rx_data, e);
  endtask

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !irq && !sd_oe && sclk_oe && sclk_o, "R1 reset", {busy, irq, sd_oe, sclk_oe, sclk_o}, 5'b00011);
    run_int(2'd0, 8'd0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
    run_int(2'd1, 8'd1, 1'b1, 1'b1, 8'h81, 8'hF0, 1'b0);
    run_int(2'd3, 8'd0, 1'b1, 1'b0, 8'h01, 8'h80, 1'b0);
    run_int(2'd0, 8'd3, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b1);
    for (int t = 0; t < 10; t++)
      run_int(2'($urandom % 3), 8'($urandom % 4), 1'($urandom), 1'($urandom),
              8'($urandom), 8'($urandom), 1'b0);
    run_ext(1'b0, 1'b0, 1'b1, 8'h5A, 8'hC3);
    run_ext(1'b1, 1'b1, 1'b0, 8'h96, 8'h0F);
    for (int t = 0; t < 4; t++)
      run_ext(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule